// File: doc/BRIEF.md
# PLL Operating Mode Controller

This block is the mode sequencer for a jitter-attenuating PLL. It starts in an initialisation state and waits for the start-up sequence to finish. After that it steps through four operating modes: free-run, lock acquisition, locked and holdover. It reacts to a few condition flags: clock-input qualification, the selected input's validity, phase lock, and whether holdover history is usable. The analog loop, the phase detector, holdover averaging and qualification timing all live elsewhere. They reach this block only as those flags.

The block also chooses the bandwidth code that drives the loop filter. Two programmed codes are available: a narrow one for normal tracking and a wider one for quick acquisition. The wider one is applied only while the loop is acquiring and the quick-acquire option is switched on. Both codes pass through without any change. Every flag is sampled on the rising clock edge, and each mode change takes effect one cycle after the condition that causes it.

Top module: `pll_mode_ctrl`

## Requirements
- R1: From reset, and for as long as `init_done` has not been seen high, `mode` reads 2'b00, `init_busy` is 1 and the controller makes no mode move.
- R2: A cycle in the initialisation state with `init_done` high puts the controller in free-run (`mode` 2'b00, `init_busy` 0) on the next cycle.
- R3: An input counts as usable when `sel_valid` is 1 and at least one bit of `in_qual` is 1. In free-run, a usable input moves `mode` to lock acquisition (2'b01) on the next cycle. `sel_valid` with all of `in_qual` at zero leaves the controller in free-run.
- R4: In lock acquisition with a usable input and `phase_lock` high, `mode` becomes locked (2'b10) on the next cycle. Otherwise, while the input stays usable, acquisition continues.
- R5: In locked, loss of the usable input with `hold_hist_ok` high moves `mode` to holdover (2'b11) on the next cycle.
- R6: In locked, loss of the usable input with `hold_hist_ok` low moves `mode` to free-run (2'b00) on the next cycle.
- R7: In locked, `phase_lock` going low while the input is still usable moves `mode` back to lock acquisition (2'b01) on the next cycle.
- R8: In holdover, a usable input moves `mode` to lock acquisition on the next cycle. Without one, the controller stays in holdover.
- R9: In lock acquisition, loss of the usable input moves `mode` to free-run on the next cycle, whatever `hold_hist_ok` is.
- R10: `bw_active` equals `bw_fast` in the same cycle while `mode` is 2'b01 and `fastlock_en` is 1, and `fastlock_on` is then 1. In every other case `bw_active` equals `bw_norm` and `fastlock_on` is 0.
- R11: Once initialisation has completed, `init_done` has no effect. Dropping it never returns the controller to the initialisation state.
- R12: `is_locked` is 1 exactly when `mode` is 2'b10 after init, and `in_holdover` is 1 exactly when `mode` is 2'b11. `init_busy` is 1 only in the initialisation state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_done | input | 1 | Start-up sequence finished |
| in_qual | input | NUM_INPUTS | Per-input qualification flags |
| sel_valid | input | 1 | Currently selected input is valid |
| phase_lock | input | 1 | Phase lock reported by the detector |
| hold_hist_ok | input | 1 | Holdover history is usable |
| fastlock_en | input | 1 | Quick-acquire bandwidth option |
| bw_norm | input | BW_W | Normal loop bandwidth code |
| bw_fast | input | BW_W | Quick-acquire bandwidth code |
| mode | output | 2 | 00 free-run, 01 acquiring, 10 locked, 11 holdover |
| bw_active | output | BW_W | Bandwidth code applied to the loop filter |
| fastlock_on | output | 1 | Quick-acquire code is being applied |
| init_busy | output | 1 | Still in initialisation |
| is_locked | output | 1 | Locked mode |
| in_holdover | output | 1 | Holdover mode |

## Verification
The bench covers several corner cases, each tied to a specific wrong behaviour:

- **Input lost while locked:** it checks both settings of the history flag. A design that ignored `hold_hist_ok` would show 2'b11 where 2'b00 is expected, or the reverse.
- **Input lost during acquisition:** a design that ran this case through the holdover rule would wrongly enter holdover.
- **Selected but unqualified input:** a design that trusted `sel_valid` alone would start acquiring.
- **Lock lost with the input still good:** a design that dropped to free-run would show the wrong code.
- **Dropping `init_done` later:** a design that re-entered initialisation would raise `init_busy`.
- **Bandwidth codes:** `fastlock_en` toggles while the programmed codes change every cycle. This exposes a swapped mux select, or a code applied outside acquisition.

// File: rtl/pll_mode_pkg.sv
package pll_mode_pkg;

   localparam int MODE_W = 2;

   // Low two bits are the externally visible mode code; bit 2 marks start-up.
   typedef enum logic [2:0] {
      ST_FREE = 3'b000,
      ST_ACQ  = 3'b001,
      ST_LOCK = 3'b010,
      ST_HOLD = 3'b011,
      ST_INIT = 3'b100
   } pll_state_e;

   function automatic logic [MODE_W-1:0] mode_of(pll_state_e s);
      return s[MODE_W-1:0];
   endfunction

endpackage

// File: rtl/pll_mode_qual.sv
module pll_mode_qual #(
   parameter int NUM_INPUTS = 4,
   parameter bit GATE_BY_QUAL = 1'b1
) (
   input  logic [NUM_INPUTS-1:0] in_qual,
   input  logic                  sel_valid,
   output logic                  in_ok
);

   if (NUM_INPUTS < 1) begin : g_bad_n
      $error("pll_mode_qual: NUM_INPUTS must be at least 1");
   end

   if (GATE_BY_QUAL) begin : g_gated
      logic any_qual;
      always_comb begin
         any_qual = 1'b0;
         for (int i = 0; i < NUM_INPUTS; i++) begin
            any_qual = any_qual | in_qual[i];
         end
      end
      assign in_ok = sel_valid & any_qual;
   end else begin : g_direct
      logic unused_qual;
      assign unused_qual = ^in_qual;
      assign in_ok = sel_valid;
   end

endmodule

// File: rtl/pll_mode_fsm.sv
module pll_mode_fsm
   import pll_mode_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       init_done,
   input  logic       in_ok,
   input  logic       phase_lock,
   input  logic       hold_hist_ok,
   output pll_state_e state_q
);

   pll_state_e state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_INIT: if (init_done) state_d = ST_FREE;
         ST_FREE: if (in_ok) state_d = ST_ACQ;
         ST_ACQ: begin
            if (!in_ok)          state_d = ST_FREE;
            else if (phase_lock) state_d = ST_LOCK;
         end
         ST_LOCK: begin
            if (!in_ok)           state_d = hold_hist_ok ? ST_HOLD : ST_FREE;
            else if (!phase_lock) state_d = ST_ACQ;
         end
         ST_HOLD: if (in_ok) state_d = ST_ACQ;
         default: state_d = ST_INIT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_INIT;
      else        state_q <= state_d;
   end

   AST_INIT_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_INIT && !init_done) |=> state_q == ST_INIT); // R1
   AST_INIT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_INIT && init_done) |=> state_q == ST_FREE); // R2
   AST_FREE_START: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_FREE && in_ok) |=> state_q == ST_ACQ); // R3
   AST_ACQ_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ACQ && in_ok && phase_lock) |=> state_q == ST_LOCK); // R4
   AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_LOCK && !in_ok && hold_hist_ok) |=> state_q == ST_HOLD); // R5
   AST_LOCK_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_LOCK && !in_ok && !hold_hist_ok) |=> state_q == ST_FREE); // R6
   AST_LOCK_SLIP: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_LOCK && in_ok && !phase_lock) |=> state_q == ST_ACQ); // R7
   AST_HOLD_BACK: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_HOLD && in_ok) |=> state_q == ST_ACQ); // R8
   AST_ACQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ACQ && !in_ok) |=> state_q == ST_FREE); // R9
   AST_NO_REINIT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_INIT) |=> state_q != ST_INIT); // R11

endmodule

// File: rtl/pll_mode_bw.sv
module pll_mode_bw
   import pll_mode_pkg::*;
#(
   parameter int BW_W    = 8,
   parameter bit REG_OUT = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  pll_state_e      state_q,
   input  logic            fastlock_en,
   input  logic [BW_W-1:0] bw_norm,
   input  logic [BW_W-1:0] bw_fast,
   output logic [BW_W-1:0] bw_active,
   output logic            fastlock_on
);

   if (BW_W < 1) begin : g_bad_w
      $error("pll_mode_bw: BW_W must be at least 1");
   end

   logic            use_fast;
   logic [BW_W-1:0] bw_pick;

   assign use_fast = (state_q == ST_ACQ) && fastlock_en;
   assign bw_pick  = use_fast ? bw_fast : bw_norm;

   if (REG_OUT) begin : g_reg
      logic [BW_W-1:0] bw_q;
      logic            fast_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bw_q   <= '0;
            fast_q <= 1'b0;
         end else begin
            bw_q   <= bw_pick;
            fast_q <= use_fast;
         end
      end
      assign bw_active   = bw_q;
      assign fastlock_on = fast_q;
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk  = clk ^ rst_n;
      assign bw_active   = bw_pick;
      assign fastlock_on = use_fast;

      AST_BW_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
         fastlock_on ? (bw_active == bw_fast) : (bw_active == bw_norm)); // R10
      AST_FAST_ONLY_ACQ: assert property (@(posedge clk) disable iff (!rst_n)
         fastlock_on |-> (mode_of(state_q) == 2'b01 && state_q != ST_INIT)); // R10
   end

endmodule

// File: rtl/pll_mode_ctrl.sv
module pll_mode_ctrl
   import pll_mode_pkg::*;
#(
   parameter int NUM_INPUTS   = 4,
   parameter int BW_W         = 8,
   parameter bit GATE_BY_QUAL = 1'b1,
   parameter bit REG_BW_OUT   = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  init_done,
   input  logic [NUM_INPUTS-1:0] in_qual,
   input  logic                  sel_valid,
   input  logic                  phase_lock,
   input  logic                  hold_hist_ok,
   input  logic                  fastlock_en,
   input  logic [BW_W-1:0]       bw_norm,
   input  logic [BW_W-1:0]       bw_fast,
   output logic [1:0]            mode,
   output logic [BW_W-1:0]       bw_active,
   output logic                  fastlock_on,
   output logic                  init_busy,
   output logic                  is_locked,
   output logic                  in_holdover
);

   localparam int MODE_BITS = MODE_W;

   if (MODE_BITS != 2) begin : g_bad_mode
      $error("pll_mode_ctrl: mode encoding must be two bits");
   end

   logic       in_ok;
   pll_state_e state_q;

   pll_mode_qual #(
      .NUM_INPUTS  (NUM_INPUTS),
      .GATE_BY_QUAL(GATE_BY_QUAL)
   ) u_qual (
      .in_qual  (in_qual),
      .sel_valid(sel_valid),
      .in_ok    (in_ok)
   );

   pll_mode_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .init_done   (init_done),
      .in_ok       (in_ok),
      .phase_lock  (phase_lock),
      .hold_hist_ok(hold_hist_ok),
      .state_q     (state_q)
   );

   pll_mode_bw #(
      .BW_W   (BW_W),
      .REG_OUT(REG_BW_OUT)
   ) u_bw (
      .clk        (clk),
      .rst_n      (rst_n),
      .state_q    (state_q),
      .fastlock_en(fastlock_en),
      .bw_norm    (bw_norm),
      .bw_fast    (bw_fast),
      .bw_active  (bw_active),
      .fastlock_on(fastlock_on)
   );

   assign mode        = mode_of(state_q);
   assign init_busy   = (state_q == ST_INIT);
   assign is_locked   = (state_q == ST_LOCK);
   assign in_holdover = (state_q == ST_HOLD);

   AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({init_busy, is_locked, in_holdover})); // R12
   AST_BUSY_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      init_busy |-> mode == 2'b00); // R1
   AST_LOCK_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      is_locked |-> mode == 2'b10); // R12

endmodule

// File: tb/pll_mode_ctrl_test.sv
`timescale 1ns/1ps
module pll_mode_ctrl_test;

   localparam int N  = 4;
   localparam int BW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          init_done = 1'b0;
   logic [N-1:0]  in_qual = '0;
   logic          sel_valid = 1'b0;
   logic          phase_lock = 1'b0;
   logic          hold_hist_ok = 1'b0;
   logic          fastlock_en = 1'b0;
   logic [BW-1:0] bw_norm = 8'h11;
   logic [BW-1:0] bw_fast = 8'hA5;
   logic [1:0]    mode;
   logic [BW-1:0] bw_active;
   logic          fastlock_on, init_busy, is_locked, in_holdover;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   pll_mode_ctrl #(.NUM_INPUTS(N), .BW_W(BW)) uut (
      .clk(clk), .rst_n(rst_n), .init_done(init_done), .in_qual(in_qual),
      .sel_valid(sel_valid), .phase_lock(phase_lock), .hold_hist_ok(hold_hist_ok),
      .fastlock_en(fastlock_en), .bw_norm(bw_norm), .bw_fast(bw_fast),
      .mode(mode), .bw_active(bw_active), .fastlock_on(fastlock_on),
      .init_busy(init_busy), .is_locked(is_locked), .in_holdover(in_holdover)
   );

   // Reference model: 0 free, 1 acquiring, 2 locked, 3 holdover, 4 start-up.
   int    m_st  = 4;
   string m_tag = "R1";

   always @(posedge clk) begin
      bit good;
      good = sel_valid && (in_qual != 0);
      if (!rst_n) begin
         m_st  <= 4;
         m_tag <= "R1";
      end else begin
         case (m_st)
            4: if (init_done) begin m_st <= 0; m_tag <= "R2"; end
               else m_tag <= "R1";
            0: if (good) begin m_st <= 1; m_tag <= "R3"; end
               else m_tag <= init_done ? "R3" : "R11";
            1: if (!good) begin m_st <= 0; m_tag <= "R9"; end
               else if (phase_lock) begin m_st <= 2; m_tag <= "R4"; end
               else m_tag <= "R4";
            2: if (!good) begin
                  m_st  <= hold_hist_ok ? 3 : 0;
                  m_tag <= hold_hist_ok ? "R5" : "R6";
               end else if (!phase_lock) begin m_st <= 1; m_tag <= "R7"; end
               else m_tag <= init_done ? "R4" : "R11";
            default: if (good) begin m_st <= 1; m_tag <= "R8"; end
               else m_tag <= "R8";
         endcase
      end
   end

   task automatic check(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      int exp_mode;
      bit exp_fast;
      exp_mode = (m_st == 4) ? 0 : m_st;
      exp_fast = (m_st == 1) && fastlock_en;
      check(m_tag, "mode", int'(mode), exp_mode);
      check("R10", "bw_active", int'(bw_active), exp_fast ? int'(bw_fast) : int'(bw_norm));
      check("R10", "fastlock_on", int'(fastlock_on), int'(exp_fast));
      check("R12", "init_busy", int'(init_busy), int'(m_st == 4));
      check("R12", "is_locked", int'(is_locked), int'(m_st == 2));
      check("R12", "in_holdover", int'(in_holdover), int'(m_st == 3));
   endtask

   // Check at the falling edge, then present the next input set.
   task automatic step(bit id, logic [N-1:0] q, bit sv, bit pl, bit hh, bit fe, int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         compare_all();
         init_done = id; in_qual = q; sel_valid = sv; phase_lock = pl;
         hold_hist_ok = hh; fastlock_en = fe;
         bw_norm = bw_norm + 8'd3; bw_fast = bw_fast ^ 8'h5C;
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) begin @(negedge clk); compare_all(); end      // R1 under reset
      rst_n = 1'b1;
      step(0, 4'h0, 0, 0, 0, 1, 4);          // R1 waiting for init
      step(0, 4'h3, 1, 1, 1, 1, 3);          // R1 inputs ignored before init
      step(1, 4'h0, 1, 0, 0, 1, 4);          // R2, then R3 sel without qual
      step(1, 4'h2, 1, 0, 0, 1, 5);          // R3 start acquiring, R10 fast code
      step(1, 4'h2, 1, 1, 1, 0, 3);          // R4 lock, R10 normal code
      step(1, 4'h0, 0, 1, 1, 1, 3);          // R5 holdover
      step(1, 4'h8, 1, 0, 1, 1, 2);          // R8 back to acquiring
      step(1, 4'h8, 1, 1, 0, 1, 2);          // R4 lock again
      step(1, 4'h8, 0, 1, 0, 1, 3);          // R6 free-run without history
      step(1, 4'h1, 1, 0, 1, 1, 2);          // R3
      step(1, 4'h1, 1, 1, 1, 1, 2);          // R4
      step(1, 4'h1, 1, 0, 1, 1, 2);          // R7 slip back to acquiring
      step(1, 4'h0, 1, 0, 1, 1, 3);          // R9 drop during acquisition
      step(0, 4'h4, 1, 1, 0, 1, 6);          // R11 init_done low after start
      step(0, 4'h0, 0, 0, 1, 0, 3);          // R11 R5
      for (int k = 0; k < 3000; k++) begin
         bit id, sv, pl, hh, fe;
         logic [N-1:0] q;
         id = ($urandom_range(0, 9) != 0);
         sv = ($urandom_range(0, 9) < 8);
         pl = ($urandom_range(0, 9) < 6);
         hh = $urandom_range(0, 1);
         fe = $urandom_range(0, 1);
         q  = ($urandom_range(0, 5) == 0) ? '0 : N'($urandom);
         step(id, q, sv, pl, hh, fe, 1);
      end
      rst_n = 1'b0;
      step(1, 4'hF, 1, 1, 1, 1, 2);          // R1 reset returns to start-up
      rst_n = 1'b1;
      step(0, 4'hF, 1, 1, 1, 1, 3);          // R1
      step(1, 4'hF, 1, 1, 1, 1, 4);          // R2 R3 R4
      @(negedge clk); compare_all();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule